// File: doc/BRIEF.md
# Configurable UART Serial Framing Engine

This block turns bytes into asynchronous serial frames on a single transmit line and recovers bytes from a single receive line. A shared baud divider produces a one-cycle tick enable. Each bit lasts 16 ticks in normal mode or 8 ticks in fast mode. The frame shape is set at run time by plain configuration inputs: 5 to 8 data bits, a parity mode (none, even, odd or a constant "stick" value), and one or two stop bits. These inputs are expected to change only while both directions are idle.

On the parallel side, bytes enter through a valid/ready handshake and leave through a second valid/ready handshake. Each received byte carries its framing, parity, break and overrun status. A break request forces the line low for as long as it is held. The receiver reports a break when a whole frame, stop position included, is sampled low.

Top module: `uart_frame_engine`

## Requirements
- R1: One bit time lasts `divisor`×16 clock cycles when `fast_mode`=0 and `divisor`×8 cycles when `fast_mode`=1. `divisor`=1 gives the fastest line rate.
- R2: The transmitter sends a low start bit, then the data field LSB first, with length 5+`data_bits` (`data_bits` 0..3 selects 5..8 bits). Data bits above the configured length are not sent.
- R3: With `parity_en`=1 and `parity_stick`=0, one parity bit follows the data. It makes the count of ones in data plus parity even when `parity_even`=1, and odd when `parity_even`=0.
- R4: With `parity_en`=1 and `parity_stick`=1, the parity bit is 0 when `parity_even`=1 and 1 when `parity_even`=0, whatever the data.
- R5: The transmitter ends each frame with one high stop bit (`two_stop`=0) or two (`two_stop`=1). `tx_ready` stays low until the last stop bit is complete. The idle line is high.
- R6: While `break_tx` is high, `txd` is low from the following cycle on, and `tx_ready` is low.
- R7: The receiver detects a falling start edge, samples each bit at mid-bit and delivers the data right-aligned. Bits above the configured length read as zero.
- R8: `rx_parity_err` is 1 when parity is enabled and the received parity bit differs from the value R3/R4 would generate for the received data.
- R9: `rx_frame_err` is 1 when the first stop bit is sampled low. A single stop bit is checked on receive.
- R10: `rx_break` is 1 when start, data, parity (if enabled) and stop are all sampled low. Such a byte also has `rx_frame_err`=1 and data 0.
- R11: A low pulse that is high again at the middle of the start bit is discarded and delivers no byte.
- R12: `rx_valid` with its data and status holds until `rx_ready`. A frame completed while a byte is still held is dropped and sets `rx_overrun` on the held byte. `rx_overrun` clears when that byte is taken.
- R13: `divisor`=0 stops the tick. `tx_ready` is low, and a waiting `tx_valid` leaves `txd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Baud divider; ticks every `divisor` cycles, 0 stops |
| fast_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| data_bits | input | 2 | Data field length minus 5 |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | Even parity select; in stick mode selects the constant |
| parity_stick | input | 1 | Stick parity mode |
| two_stop | input | 1 | Two stop bits on transmit |
| break_tx | input | 1 | Hold transmit line low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter accepts a byte |
| txd | output | 1 | Serial transmit line (registered) |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_valid | output | 1 | Received byte held |
| rx_data | output | 8 | Received byte, right-aligned |
| rx_frame_err | output | 1 | First stop bit sampled low |
| rx_parity_err | output | 1 | Parity mismatch |
| rx_break | output | 1 | Whole frame sampled low |
| rx_overrun | output | 1 | A later frame was dropped while this byte was held |

## Verification
The assertions check these properties on every cycle:
- the transmit line is held low under a break request and stays high while idle;
- a zero divisor blocks the transmitter;
- a held received byte and its status stay stable until taken;
- overrun only ever appears on a held byte;
- a break byte always carries a framing error and zero data, and unused upper bits are zero.

Bit ordering, parity values, stop-bit counts, the exact bit duration in both oversampling modes, glitch rejection and the drop of a second unread frame depend on whole serial frames. The directed scenarios cover these, with the bench acting as an independent line encoder and decoder.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
    logic       fast;
  } frame_cfg_t;

  // Parity value to place on the line (or expect) for data d.
  function automatic logic parity_value(input logic [BYTE_W-1:0] d,
                                        input logic [1:0] len_sel,
                                        input logic par_even,
                                        input logic par_stick);
    logic [BYTE_W-1:0] mask;
    mask = 8'hFF >> (2'd3 - len_sel);
    if (par_stick) return ~par_even;
    else if (par_even) return ^(d & mask);
    else return ~^(d & mask);
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (divisor == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  frame_cfg_t        cfg,
  input  logic              break_req,
  input  logic [BYTE_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              txd
);
  tx_state_e         state;
  logic [3:0]        tcnt;
  logic [2:0]        bidx;
  logic [BYTE_W-1:0] shreg;
  logic              par_bit;
  logic              line;
  logic [3:0]        tick_last;
  logic [2:0]        bit_last;

  assign tick_last = cfg.fast ? 4'd7 : 4'd15;
  assign bit_last  = 3'd4 + {1'b0, cfg.len_sel};
  assign ready     = (state == TX_IDLE) && enable && !break_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (state == TX_IDLE) begin
      if (valid && ready) begin
        shreg   <= data;
        par_bit <= parity_value(data, cfg.len_sel, cfg.par_even, cfg.par_stick);
        tcnt    <= '0;
        bidx    <= '0;
        state   <= TX_START;
      end
    end else if (tick) begin
      if (tcnt != tick_last) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (state)
          TX_START: state <= TX_DATA;
          TX_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == bit_last) state <= cfg.par_en ? TX_PAR : TX_STOP1;
            else bidx <= bidx + 1'b1;
          end
          TX_PAR:   state <= TX_STOP1;
          TX_STOP1: state <= cfg.two_stop ? TX_STOP2 : TX_IDLE;
          default:  state <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      TX_START: line = 1'b0;
      TX_DATA:  line = shreg[0];
      TX_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= break_req ? 1'b0 : line;
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              fast,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              frame_err,
  output logic              par_err,
  output logic              brk
);
  rx_state_e         state;
  logic [3:0]        tcnt;
  logic [2:0]        bidx;
  logic [BYTE_W-1:0] shreg;
  logic              prev;
  logic              all_low;
  logic              par_rx;
  logic [3:0]        tick_last;
  logic [3:0]        half_last;
  logic [2:0]        bit_last;
  logic [BYTE_W-1:0] aligned;

  assign tick_last = fast ? 4'd7 : 4'd15;
  assign half_last = fast ? 4'd3 : 4'd7;
  assign bit_last  = 3'd4 + {1'b0, len_sel};
  assign aligned   = shreg >> (2'd3 - len_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      prev      <= 1'b1;
      all_low   <= 1'b0;
      par_rx    <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
      brk       <= 1'b0;
    end else begin
      prev <= rxd_s;
      done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (prev && !rxd_s) begin
            tcnt  <= '0;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt != half_last) begin
              tcnt <= tcnt + 1'b1;
            end else begin
              tcnt <= '0;
              if (rxd_s) begin
                state <= RX_IDLE;
              end else begin
                bidx    <= '0;
                all_low <= 1'b1;
                state   <= RX_DATA;
              end
            end
          end
        end
        default: begin
          if (tick) begin
            if (tcnt != tick_last) begin
              tcnt <= tcnt + 1'b1;
            end else begin
              tcnt    <= '0;
              all_low <= all_low & ~rxd_s;
              if (state == RX_DATA) begin
                shreg <= {rxd_s, shreg[BYTE_W-1:1]};
                if (bidx == bit_last) state <= par_en ? RX_PAR : RX_STOP;
                else bidx <= bidx + 1'b1;
              end else if (state == RX_PAR) begin
                par_rx <= rxd_s;
                state  <= RX_STOP;
              end else begin
                done      <= 1'b1;
                data      <= aligned;
                frame_err <= ~rxd_s;
                brk       <= all_low & ~rxd_s;
                par_err   <= par_en &&
                             (par_rx != parity_value(aligned, len_sel, par_even, par_stick));
                state     <= RX_IDLE;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_frame_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fast_mode,
  input  logic [1:0]       data_bits,
  input  logic             parity_en,
  input  logic             parity_even,
  input  logic             parity_stick,
  input  logic             two_stop,
  input  logic             break_tx,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_frame_err,
  output logic             rx_parity_err,
  output logic             rx_break,
  output logic             rx_overrun
);
  frame_cfg_t        cfg;
  logic              tick;
  logic              rxd_s;
  logic              rx_done;
  logic [BYTE_W-1:0] rx_word;
  logic              rx_ferr, rx_perr, rx_brk;

  assign cfg = '{len_sel: data_bits, par_en: parity_en, par_even: parity_even,
                 par_stick: parity_stick, two_stop: two_stop, fast: fast_mode};

  uart_baud_tick #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  // Input synchroniser for the asynchronous receive line
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
      assign rxd_s = sync_q[SYNC_STAGES-1];
    end else begin : g_sync_single
      logic sync_q;
      always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b1;
        else     sync_q <= rxd;
      end
      assign rxd_s = sync_q;
    end
  endgenerate

  uart_tx_core tx_i (
    .clk(clk), .rst(rst), .tick(tick), .enable(divisor != '0), .cfg(cfg),
    .break_req(break_tx), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .txd(txd)
  );

  uart_rx_core rx_i (
    .clk(clk), .rst(rst), .tick(tick), .rxd_s(rxd_s),
    .len_sel(data_bits), .par_en(parity_en), .par_even(parity_even),
    .par_stick(parity_stick), .fast(fast_mode),
    .done(rx_done), .data(rx_word), .frame_err(rx_ferr),
    .par_err(rx_perr), .brk(rx_brk)
  );

  // Output holding stage with overrun marking
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_frame_err  <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_break      <= 1'b0;
      rx_overrun    <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid   <= 1'b0;
        rx_overrun <= 1'b0;
      end
      if (rx_done) begin
        if (rx_valid && !rx_ready) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_valid      <= 1'b1;
          rx_data       <= rx_word;
          rx_frame_err  <= rx_ferr;
          rx_parity_err <= rx_perr;
          rx_break      <= rx_brk;
        end
      end
    end
  end
endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] divisor,
  input logic [1:0]       data_bits,
  input logic             break_tx,
  input logic             tx_ready,
  input logic             txd,
  input logic             rx_ready,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic             rx_frame_err,
  input logic             rx_break,
  input logic             rx_overrun
);
  // R6
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(break_tx)) |-> !txd);

  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && $past(tx_ready)) |-> txd);

  // R13
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |-> !tx_ready);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_frame_err)
                                 && $stable(rx_break)));

  // R12
  overrun_held_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> rx_valid);

  // R10
  break_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_break) |-> (rx_frame_err && rx_data == 8'h00));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && data_bits == 2'd0) |-> (rx_data[7:5] == 3'b000));
endmodule

bind uart_frame_engine uart_frame_engine_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .divisor(divisor), .data_bits(data_bits),
  .break_tx(break_tx), .tx_ready(tx_ready), .txd(txd), .rx_ready(rx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
  .rx_break(rx_break), .rx_overrun(rx_overrun)
);

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [15:0] divisor;
  logic        fast_mode;
  logic [1:0]  data_bits;
  logic        parity_en, parity_even, parity_stick, two_stop, break_tx;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready, txd;
  logic        rxd, rx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_frame_err, rx_parity_err, rx_break, rx_overrun;

  int n_chk  = 0;
  int n_fail = 0;
  int P      = 32;
  int cycles = 0;

  uart_frame_engine uut (
    .clk(clk), .rst(rst), .divisor(divisor), .fast_mode(fast_mode),
    .data_bits(data_bits), .parity_en(parity_en), .parity_even(parity_even),
    .parity_stick(parity_stick), .two_stop(two_stop), .break_tx(break_tx),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rx_break(rx_break), .rx_overrun(rx_overrun)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic configure(input int div, input bit fast, input logic [1:0] len,
                           input bit pen, input bit peven, input bit pstick, input bit stop2);
    @(negedge clk);
    divisor = 16'(div); fast_mode = fast; data_bits = len;
    parity_en = pen; parity_even = peven; parity_stick = pstick; two_stop = stop2;
    P = div * (fast ? 8 : 16);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d);
    int t = 0;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready && t < 8 * P) begin @(negedge clk); t++; end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_low();
    int t = 0;
    while (txd && t < 4 * P) begin @(negedge clk); t++; end
  endtask

  task automatic wait_tx_idle();
    int t = 0;
    while (!tx_ready && t < 16 * P) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic cap_tx(input int n, output logic [15:0] v, output logic [15:0] r);
    v = '0; r = '0;
    wait_tx_low();
    repeat (P / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      v[i] = txd; r[i] = tx_ready;
      if (i < n - 1) repeat (P) @(negedge clk);
    end
  endtask

  task automatic drive_line(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      repeat (P) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * P) @(negedge clk);
  endtask

  task automatic wait_rx(output bit got);
    int t = 0;
    while (!rx_valid && t < 4 * P) begin @(negedge clk); t++; end
    got = rx_valid;
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure_low(output int len);
    send_tx(8'h00);
    wait_tx_low();
    len = 0;
    while (!txd && len < 20 * P) begin @(negedge clk); len++; end
    wait_tx_idle();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(txd == 1'b1, "R5", "txd after reset", txd, 1);
    chk(tx_ready == 1'b1, "R5", "tx_ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R12", "rx_valid after reset", rx_valid, 0);
  endtask

  task automatic t_tx_8n1();
    logic [15:0] v, r;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    send_tx(8'hA5);
    cap_tx(10, v, r);
    chk(v[9:0] == {1'b1, 8'hA5, 1'b0}, "R2", "8N1 frame", v, {1'b1, 8'hA5, 1'b0});
    chk(r[9] == 1'b0, "R5", "ready during stop", r[9], 0);
    wait_tx_idle();
  endtask

  task automatic t_tx_5e2();
    logic [15:0] v, r;
    configure(2, 0, 2'd0, 1, 1, 0, 1);
    send_tx(8'hFB);
    cap_tx(9, v, r);
    chk(v[8:0] == {2'b11, 1'b0, 5'h1B, 1'b0}, "R3", "5E2 frame", v,
        {2'b11, 1'b0, 5'h1B, 1'b0});
    chk(r[8] == 1'b0, "R5", "ready in second stop", r[8], 0);
    wait_tx_idle();
  endtask

  task automatic t_tx_7o1();
    logic [15:0] v, r;
    configure(2, 0, 2'd2, 1, 0, 0, 0);
    send_tx(8'h55);
    cap_tx(10, v, r);
    chk(v[9:0] == {1'b1, 1'b1, 7'h55, 1'b0}, "R3", "7O1 frame", v,
        {1'b1, 1'b1, 7'h55, 1'b0});
    wait_tx_idle();
  endtask

  task automatic t_tx_stick();
    logic [15:0] v, r;
    configure(2, 0, 2'd3, 1, 1, 1, 0);
    send_tx(8'h01);
    cap_tx(11, v, r);
    chk(v[9] == 1'b0, "R4", "stick select 1 gives 0", v[9], 0);
    wait_tx_idle();
    configure(2, 0, 2'd3, 1, 0, 1, 0);
    send_tx(8'h01);
    cap_tx(11, v, r);
    chk(v[9] == 1'b1, "R4", "stick select 0 gives 1", v[9], 1);
    wait_tx_idle();
  endtask

  task automatic t_timing();
    int len;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    measure_low(len);
    chk(len >= 9 * 32 - 4 && len <= 9 * 32 + 4, "R1", "normal 9-bit low time", len, 9 * 32);
    configure(3, 1, 2'd3, 0, 0, 0, 0);
    measure_low(len);
    chk(len >= 9 * 24 - 5 && len <= 9 * 24 + 5, "R1", "fast 9-bit low time", len, 9 * 24);
    configure(1, 1, 2'd3, 0, 0, 0, 0);
    measure_low(len);
    chk(len >= 9 * 8 - 3 && len <= 9 * 8 + 3, "R1", "max rate low time", len, 9 * 8);
  endtask

  task automatic t_break_tx();
    int highs = 0;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    break_tx = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R6", "tx_ready under break", tx_ready, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd) highs++;
    end
    chk(highs == 0, "R6", "high samples under break", highs, 0);
    break_tx = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1 && tx_ready == 1'b1, "R6", "line after break", txd, 1);
  endtask

  task automatic t_rx_basic();
    bit got;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    drive_line({1'b1, 8'h3C, 1'b0}, 10);
    wait_rx(got);
    chk(got && rx_data == 8'h3C, "R7", "8N1 receive", rx_data, 8'h3C);
    chk({rx_frame_err, rx_parity_err, rx_break, rx_overrun} == 4'b0, "R7", "clean status",
        {rx_frame_err, rx_parity_err, rx_break, rx_overrun}, 0);
    take_rx();
    configure(2, 0, 2'd1, 0, 0, 0, 0);
    drive_line({1'b1, 6'h3F, 1'b0}, 8);
    wait_rx(got);
    chk(got && rx_data == 8'h3F, "R7", "6-bit receive zero-extended", rx_data, 8'h3F);
    take_rx();
    configure(2, 1, 2'd0, 0, 0, 0, 0);
    drive_line({1'b1, 5'h15, 1'b0}, 7);
    wait_rx(got);
    chk(got && rx_data == 8'h15, "R7", "5-bit fast receive", rx_data, 8'h15);
    take_rx();
    chk(rx_valid == 1'b0, "R12", "valid cleared by ready", rx_valid, 0);
  endtask

  task automatic t_rx_parity();
    bit got;
    configure(2, 0, 2'd3, 1, 1, 0, 0);
    drive_line({1'b1, 1'b1, 8'h07, 1'b0}, 11);
    wait_rx(got);
    chk(got && !rx_parity_err, "R8", "good even parity", rx_parity_err, 0);
    take_rx();
    drive_line({1'b1, 1'b0, 8'h07, 1'b0}, 11);
    wait_rx(got);
    chk(got && rx_parity_err && rx_data == 8'h07, "R8", "bad even parity", rx_parity_err, 1);
    take_rx();
  endtask

  task automatic t_rx_frame();
    bit got;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    drive_line({1'b0, 8'h5A, 1'b0}, 10);
    wait_rx(got);
    chk(got && rx_frame_err && !rx_break && rx_data == 8'h5A, "R9", "low stop bit",
        {rx_frame_err, rx_break}, 2'b10);
    take_rx();
  endtask

  task automatic t_rx_break();
    bit got;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    rxd = 1'b0;
    repeat (10 * P) @(negedge clk);
    got = rx_valid;
    chk(got && rx_break && rx_frame_err && rx_data == 8'h00, "R10", "break detect",
        {rx_break, rx_frame_err}, 2'b11);
    take_rx();
    repeat (2 * P) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * P) @(negedge clk);
    chk(rx_valid == 1'b0, "R10", "single byte per break", rx_valid, 0);
  endtask

  task automatic t_glitch();
    bit got;
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    rxd = 1'b0;
    repeat (P / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * P) @(negedge clk);
    chk(rx_valid == 1'b0, "R11", "glitch delivers nothing", rx_valid, 0);
    drive_line({1'b1, 8'hC3, 1'b0}, 10);
    wait_rx(got);
    chk(got && rx_data == 8'hC3, "R11", "frame after glitch", rx_data, 8'hC3);
    take_rx();
  endtask

  task automatic t_overrun();
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    drive_line({1'b1, 8'h11, 1'b0}, 10);
    drive_line({1'b1, 8'h22, 1'b0}, 10);
    chk(rx_valid && rx_data == 8'h11, "R12", "held byte kept", rx_data, 8'h11);
    chk(rx_overrun == 1'b1, "R12", "overrun marked", rx_overrun, 1);
    take_rx();
    chk(rx_valid == 1'b0 && rx_overrun == 1'b0, "R12", "dropped byte not delivered",
        {rx_valid, rx_overrun}, 0);
  endtask

  task automatic t_div_zero();
    int lows = 0;
    configure(0, 0, 2'd3, 0, 0, 0, 0);
    chk(tx_ready == 1'b0, "R13", "tx_ready with zero divisor", tx_ready, 0);
    tx_data = 8'h00; tx_valid = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    tx_valid = 1'b0;
    chk(lows == 0, "R13", "line stays idle", lows, 0);
    configure(2, 0, 2'd3, 0, 0, 0, 0);
    chk(tx_ready == 1'b1, "R13", "ready after divisor restored", tx_ready, 1);
  endtask

  initial begin
    rst = 1'b1; divisor = 16'd2; fast_mode = 1'b0; data_bits = 2'd3;
    parity_en = 1'b0; parity_even = 1'b0; parity_stick = 1'b0; two_stop = 1'b0;
    break_tx = 1'b0; tx_data = 8'h00; tx_valid = 1'b0; rxd = 1'b1; rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_8n1();
    t_tx_5e2();
    t_tx_7o1();
    t_tx_stick();
    t_timing();
    t_break_tx();
    t_rx_basic();
    t_rx_parity();
    t_rx_frame();
    t_rx_break();
    t_glitch();
    t_overrun();
    t_div_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule